// File: doc/BRIEF.md
# Dual Accumulator Saturation Controller

This block holds two signed fixed-point accumulators, A and B, each ACC_W bits wide with GUARD_W guard bits above a low field of ACC_W-GUARD_W bits. By default this is 40 bits split into 8 guard bits and a 32-bit 1.31 word, which makes a 9.31 format. On each write cycle the block adds a signed operand to the selected accumulator, or subtracts it. The exact result is kept one bit wider than the accumulator. One of three overflow policies is then applied: clamp at the full accumulator range, clamp at the low-field range, or let the value wrap.

The block keeps four kinds of status:
- a per-accumulator overflow flag that shows whether the guard bits are in use;
- a per-accumulator sticky saturation flag that only an explicit clear input can reset;
- combined flags that OR each kind across both accumulators;
- an arithmetic trap request.

A surrounding datapath drives the operand, the target and the policy inputs, and reads the accumulators and flags directly.

Top module: `acc_sat_ctrl`

## Requirements
- R1: With `sat_en`=1 and `mode`=2'b00 (full-range clamp), an exact result above the largest positive accumulator value writes 0x7FFFFFFFFF (0 followed by all ones). An exact result below the most negative value writes 0x8000000000 (1 followed by all zeros). Either clamp sets the target's sticky saturation flag.
- R2: With `sat_en`=1 and `mode`=2'b01 (low-field clamp), an exact result above the largest positive 1.31 value writes 0x007FFFFFFF. An exact result below the most negative 1.31 value writes the pattern 0x0080000000: guard bits zero, bit LOW_W-1 set, lower bits zero. Either clamp sets the target's sticky saturation flag, and in-range results are written unchanged.
- R3: A write made with `sat_en`=1 and `mode`=2'b01 always clears the target's overflow flag.
- R4: With `sat_en`=0, or with `mode`=2'b10 or 2'b11, no clamp is done and the result wraps modulo 2^ACC_W. The target's sticky flag is set only when the exact result leaves the full accumulator range.
- R5: A sticky saturation flag stays set until its clear input (`clr_sat_a` or `clr_sat_b`) is high at a clock edge. If a clear and a new saturation event reach the same flag in the same cycle, the flag ends up set.
- R6: Outside the case in R3, every write sets the target's overflow flag exactly when the written value's guard bits are not all equal to bit LOW_W-1.
- R7: `ovf_any` equals `ovf_a` OR `ovf_b`, and `sat_any` equals `sat_a` OR `sat_b`.
- R8: `trap_req` is high when `trap_en` is 1, saturation is off (`sat_en`=0 or `mode[1]`=1), and either sticky flag is set. Otherwise it is low.
- R9: A write changes only the selected accumulator (`wr_sel`=0 selects A, 1 selects B) and its overflow flag. With `wr_en` low, both accumulators and both overflow flags hold their values.
- R10: After reset, both accumulators are zero and all flags and `trap_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Apply the operand to the selected accumulator this cycle |
| wr_sel | input | 1 | Target: 0 selects A, 1 selects B |
| sub | input | 1 | 1 subtracts the operand, 0 adds it |
| operand | input | ACC_W | Signed operand |
| mode | input | 2 | Policy: 00 full-range clamp, 01 low-field clamp, 1x wrap |
| sat_en | input | 1 | Enables the clamping policies |
| trap_en | input | 1 | Enables the trap request |
| clr_sat_a | input | 1 | Clears sticky flag A |
| clr_sat_b | input | 1 | Clears sticky flag B |
| acc_a | output | ACC_W | Accumulator A |
| acc_b | output | ACC_W | Accumulator B |
| ovf_a | output | 1 | Guard-bit overflow flag of A |
| ovf_b | output | 1 | Guard-bit overflow flag of B |
| sat_a | output | 1 | Sticky saturation flag of A |
| sat_b | output | 1 | Sticky saturation flag of B |
| ovf_any | output | 1 | OR of both overflow flags |
| sat_any | output | 1 | OR of both sticky flags |
| trap_req | output | 1 | Arithmetic trap request |

## Verification
The assertions check the following on every cycle:
- a sticky flag stays set until it is cleared;
- a sticky flag can only rise after a write to its own accumulator;
- the low-field clamp mode never leaves an overflow flag set;
- the accumulator that was not written, and both accumulators on idle cycles, do not change;
- a trap request never appears without a sticky flag set.

The clamp values, the wrap arithmetic, the set-beats-clear collision and the guard-bit overflow condition need a reference model. Only the bench's sweeps can show these. The sweeps cover every policy, both targets and add and subtract, over a grid of accumulator and operand values on a 12-bit build.

// File: rtl/acc_sat_ctrl.sv
module acc_sat_ctrl #(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic             sub,
  input  logic [ACC_W-1:0] operand,
  input  logic [1:0]       mode,
  input  logic             sat_en,
  input  logic             trap_en,
  input  logic             clr_sat_a,
  input  logic             clr_sat_b,
  output logic [ACC_W-1:0] acc_a,
  output logic [ACC_W-1:0] acc_b,
  output logic             ovf_a,
  output logic             ovf_b,
  output logic             sat_a,
  output logic             sat_b,
  output logic             ovf_any,
  output logic             sat_any,
  output logic             trap_req
);
  localparam int LOW_W = ACC_W - GUARD_W;
  localparam logic [1:0] MODE_TOP = 2'b00;
  localparam logic [1:0] MODE_LOW = 2'b01;
  localparam logic [ACC_W-1:0] TOP_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] TOP_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] LOW_MAX = {{(GUARD_W+1){1'b0}}, {(LOW_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] LOW_MIN = {{GUARD_W{1'b0}}, 1'b1, {(LOW_W-1){1'b0}}};

  logic [ACC_W-1:0] cur, nxt;
  logic [ACC_W:0]   cur_x, op_x, exact;
  logic [GUARD_W+1:0] ex_hi;
  logic [GUARD_W:0]   nx_hi;
  logic top_ovf, low_ovf, neg, sat_on, low_mode, sat_evt, ovf_new;

  assign cur      = wr_sel ? acc_b : acc_a;
  assign cur_x    = {cur[ACC_W-1], cur};
  assign op_x     = {operand[ACC_W-1], operand};
  assign exact    = sub ? cur_x - op_x : cur_x + op_x;
  assign neg      = exact[ACC_W];
  assign top_ovf  = exact[ACC_W] ^ exact[ACC_W-1];
  assign ex_hi    = exact[ACC_W:LOW_W-1];
  assign low_ovf  = !((&ex_hi) || !(|ex_hi));
  assign sat_on   = sat_en && !mode[1];
  assign low_mode = sat_on && (mode == MODE_LOW);

  always_comb begin
    nxt = exact[ACC_W-1:0];
    if (sat_on && mode == MODE_TOP && top_ovf)
      nxt = neg ? TOP_MIN : TOP_MAX;
    else if (low_mode && low_ovf)
      nxt = neg ? LOW_MIN : LOW_MAX;
  end

  assign sat_evt = low_mode ? low_ovf : top_ovf;
  assign nx_hi   = nxt[ACC_W-1:LOW_W-1];
  assign ovf_new = !low_mode && !((&nx_hi) || !(|nx_hi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_a <= '0;
      acc_b <= '0;
      ovf_a <= 1'b0;
      ovf_b <= 1'b0;
      sat_a <= 1'b0;
      sat_b <= 1'b0;
    end else begin
      if (wr_en && !wr_sel) begin
        acc_a <= nxt;
        ovf_a <= ovf_new;
      end
      if (wr_en && wr_sel) begin
        acc_b <= nxt;
        ovf_b <= ovf_new;
      end
      sat_a <= (sat_a && !clr_sat_a) || (wr_en && !wr_sel && sat_evt);
      sat_b <= (sat_b && !clr_sat_b) || (wr_en && wr_sel && sat_evt);
    end
  end

  assign ovf_any  = ovf_a | ovf_b;
  assign sat_any  = sat_a | sat_b;
  assign trap_req = trap_en && !sat_on && sat_any;
endmodule

// File: rtl/acc_sat_ctrl_chk.sv
module acc_sat_ctrl_chk #(
  parameter int ACC_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [1:0]       mode,
  input logic             sat_en,
  input logic             clr_sat_a,
  input logic             clr_sat_b,
  input logic [ACC_W-1:0] acc_a,
  input logic [ACC_W-1:0] acc_b,
  input logic             ovf_a,
  input logic             ovf_b,
  input logic             sat_a,
  input logic             sat_b,
  input logic             trap_req
);
  p_sticky_hold_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sat_a && !clr_sat_a |=> sat_a);
  p_sticky_hold_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sat_b && !clr_sat_b |=> sat_b);
  p_sticky_src_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_a) |-> $past(wr_en && !wr_sel));
  p_sticky_src_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_b) |-> $past(wr_en && wr_sel));
  p_no_overflow_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel && sat_en && mode == 2'b01 |=> !ovf_a);
  p_no_overflow_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel && sat_en && mode == 2'b01 |=> !ovf_b);
  p_other_hold_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel |=> $stable(acc_b) && $stable(ovf_b));
  p_other_hold_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel |=> $stable(acc_a) && $stable(ovf_a));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(acc_a) && $stable(acc_b) && $stable(ovf_a) && $stable(ovf_b));
  p_trap_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> sat_a || sat_b);
endmodule

bind acc_sat_ctrl acc_sat_ctrl_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .mode(mode),
  .sat_en(sat_en), .clr_sat_a(clr_sat_a), .clr_sat_b(clr_sat_b),
  .acc_a(acc_a), .acc_b(acc_b), .ovf_a(ovf_a), .ovf_b(ovf_b),
  .sat_a(sat_a), .sat_b(sat_b), .trap_req(trap_req)
);

// File: tb/acc_sat_ctrl_test.sv
module acc_sat_ctrl_test;
  localparam int AW = 12;
  localparam int GW = 4;
  localparam int LW = AW - GW;
  localparam int TMAX = (1 << (AW-1)) - 1;
  localparam int TMIN = -(1 << (AW-1));
  localparam int LMAX = (1 << (LW-1)) - 1;
  localparam int LMIN = -(1 << (LW-1));

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, sub = 1'b0;
  logic [AW-1:0] operand = '0;
  logic [1:0] mode = 2'b00;
  logic sat_en = 1'b0, trap_en = 1'b0, clr_sat_a = 1'b0, clr_sat_b = 1'b0;
  logic [AW-1:0] acc_a, acc_b;
  logic ovf_a, ovf_b, sat_a, sat_b, ovf_any, sat_any, trap_req;

  int total = 0, bad = 0;
  int ma [2];
  bit mo [2];
  bit ms [2];

  always #4 clk = ~clk;

  acc_sat_ctrl #(.ACC_W(AW), .GUARD_W(GW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .sub(sub),
    .operand(operand), .mode(mode), .sat_en(sat_en), .trap_en(trap_en),
    .clr_sat_a(clr_sat_a), .clr_sat_b(clr_sat_b), .acc_a(acc_a), .acc_b(acc_b),
    .ovf_a(ovf_a), .ovf_b(ovf_b), .sat_a(sat_a), .sat_b(sat_b),
    .ovf_any(ovf_any), .sat_any(sat_any), .trap_req(trap_req)
  );

  function automatic int sx(logic [AW-1:0] v);
    return v[AW-1] ? int'(v) - (1 << AW) : int'(v);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag, string otag);
    chk(tag, "acc_a", sx(acc_a), ma[0]);
    chk(tag, "acc_b", sx(acc_b), ma[1]);
    chk(otag, "ovf_a", int'(ovf_a), int'(mo[0]));
    chk(otag, "ovf_b", int'(ovf_b), int'(mo[1]));
    chk(tag, "sat_a", int'(sat_a), int'(ms[0]));
    chk(tag, "sat_b", int'(sat_b), int'(ms[1]));
    chk("R7", "ovf_any", int'(ovf_any), int'(mo[0] | mo[1]));
    chk("R7", "sat_any", int'(sat_any), int'(ms[0] | ms[1]));
    chk("R8", "trap_req", int'(trap_req),
        int'(trap_en && (!sat_en || mode[1]) && (ms[0] || ms[1])));
  endtask

  // one write plus optional clears, model updated alongside
  task automatic wr(bit sel, bit sb, logic [AW-1:0] opv, bit ca, bit cb);
    int ex, r;
    bit on, evt;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; sub = sb; operand = opv;
    clr_sat_a = ca; clr_sat_b = cb;
    on = sat_en && !mode[1];
    ex = sb ? ma[sel] - sx(opv) : ma[sel] + sx(opv);
    evt = 1'b0;
    if (on && mode == 2'b00) begin
      if (ex > TMAX) begin r = TMAX; evt = 1'b1; end
      else if (ex < TMIN) begin r = TMIN; evt = 1'b1; end
      else r = ex;
    end else if (on && mode == 2'b01) begin
      if (ex > LMAX) begin r = LMAX; evt = 1'b1; end
      else if (ex < LMIN) begin r = 1 << (LW-1); evt = 1'b1; end
      else r = ex;
    end else begin
      evt = (ex > TMAX) || (ex < TMIN);
      r = ((ex % (1 << AW)) + (1 << AW)) % (1 << AW);
      if (r > TMAX) r = r - (1 << AW);
    end
    ma[sel] = r;
    mo[sel] = (on && mode == 2'b01) ? 1'b0 : ((r > LMAX) || (r < LMIN));
    ms[0] = (ms[0] && !ca) || (!sel && evt);
    ms[1] = (ms[1] && !cb) || (sel && evt);
    @(negedge clk);
    wr_en = 1'b0; clr_sat_a = 1'b0; clr_sat_b = 1'b0;
  endtask

  task automatic clr_both();
    @(negedge clk);
    clr_sat_a = 1'b1; clr_sat_b = 1'b1;
    ms[0] = 1'b0; ms[1] = 1'b0;
    @(negedge clk);
    clr_sat_a = 1'b0; clr_sat_b = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    string tag, otag;
    ma[0] = 0; ma[1] = 0; mo[0] = 0; mo[1] = 0; ms[0] = 0; ms[1] = 0;
    repeat (3) @(negedge clk);
    chk_all("R10", "R10");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R10", "R10");

    // idle cycles leave everything alone
    repeat (3) @(negedge clk);
    chk_all("R9", "R9");

    for (int cfg = 0; cfg < 5; cfg++) begin
      case (cfg)
        0: begin sat_en = 1'b1; mode = 2'b00; tag = "R1"; otag = "R6"; end
        1: begin sat_en = 1'b1; mode = 2'b01; tag = "R2"; otag = "R3"; end
        2: begin sat_en = 1'b1; mode = 2'b10; tag = "R4"; otag = "R6"; end
        3: begin sat_en = 1'b0; mode = 2'b00; tag = "R4"; otag = "R6"; end
        default: begin sat_en = 1'b0; mode = 2'b01; tag = "R4"; otag = "R6"; end
      endcase
      trap_en = (cfg != 0);
      for (int i = 0; i < 32; i++) begin
        for (int j = 0; j < 32; j++) begin
          for (int s = 0; s < 2; s++) begin
            bit sel;
            logic [AW-1:0] xv, yv;
            sel = bit'((i + j + s) & 1);
            xv = AW'(i * 128 + (i * 37) % 128);
            yv = AW'(j * 128 + (j * 53 + 1) % 128);
            wr(sel, 1'b1, AW'(ma[sel]), 1'b0, 1'b0);
            wr(sel, 1'b0, xv, 1'b0, 1'b0);
            wr(sel, bit'(s), yv, 1'b0, 1'b0);
            chk_all(tag, otag);
            clr_both();
          end
        end
      end
    end

    // R5: sticky flag survives idle cycles and a clear of the other flag
    sat_en = 1'b1; mode = 2'b00; trap_en = 1'b0;
    wr(1'b0, 1'b1, AW'(ma[0]), 1'b0, 1'b0);
    wr(1'b0, 1'b0, AW'(TMAX), 1'b0, 1'b0);
    wr(1'b0, 1'b0, AW'(5), 1'b0, 1'b0);
    chk("R5", "sat_a set", int'(sat_a), 1);
    chk("R1", "acc_a clamp", sx(acc_a), TMAX);
    repeat (4) @(negedge clk);
    chk("R5", "sat_a held", int'(sat_a), 1);
    wr(1'b1, 1'b0, AW'(1), 1'b0, 1'b1);
    chk("R5", "sat_a held across other clear", int'(sat_a), 1);
    // R5: set wins over simultaneous clear
    wr(1'b0, 1'b0, AW'(7), 1'b1, 1'b0);
    chk("R5", "set beats clear", int'(sat_a), 1);
    chk_all("R5", "R6");
    // clear without a new event
    wr(1'b0, 1'b1, AW'(1), 1'b1, 1'b0);
    chk("R5", "cleared", int'(sat_a), 0);
    chk_all("R5", "R6");
    // R8: trap follows the enable and the policy
    wr(1'b1, 1'b1, AW'(ma[1]), 1'b0, 1'b0);
    sat_en = 1'b0; trap_en = 1'b1;
    wr(1'b1, 1'b0, AW'(TMAX), 1'b0, 1'b0);
    wr(1'b1, 1'b0, AW'(1), 1'b0, 1'b0);
    chk("R4", "wrap to min", sx(acc_b), TMIN);
    chk("R8", "trap raised", int'(trap_req), 1);
    @(negedge clk); trap_en = 1'b0; #1;
    chk("R8", "trap off when disabled", int'(trap_req), 0);
    @(negedge clk); trap_en = 1'b1; sat_en = 1'b1; mode = 2'b01; #1;
    chk("R8", "trap off with clamp active", int'(trap_req), 0);
    chk_all("R8", "R6");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule